// File: doc/BRIEF.md
# Prescaled 54-bit Alarm Timer

This block is a single general purpose timer driven through a small synchronous register port. A 54-bit counter advances once every N clocks, where N comes from a programmable prescaler. It counts up or down and wraps modulo 2^54. A comparator raises an alarm event when the count reaches a programmed threshold. That event can reload the counter from a preset value, and it sets a sticky interrupt bit that can be masked.

Software can copy the preset value into the counter at any time. It can also request a snapshot of the live count. The snapshot goes through a toggle request/acknowledge handshake, and the request bit reads back as 1 until the captured value has landed in the readable count words. The block also holds the code for the timer's source clock and drives it on a pin. The register port has no back-pressure: every write takes effect on the clock edge where `bus_we` is high, and `bus_rdata` is a combinational function of `bus_addr`.

Top module: `tmr_alarm_timer`

## Requirements
- R1: After reset the register reads are:
  - control (0x00) reads 0x2: counting stopped, direction up, no auto-reload, alarm disarmed.
  - divider (0x04) reads 2.
  - every other register reads 0.
  - `irq` is 0 and `clk_sel` is 0.
- R2: With divider field (0x04, bits 15:0) equal to N in 2..65535, the counter steps once every N clocks while enabled. Field 0 gives a ratio of 65536. Field 1 behaves as a ratio of 2.
- R3: A write to the divider register restarts the prescaler phase. The next step comes a full ratio of clocks after that write.
- R4: Control bit 0 enables counting. Control bit 1 selects up (1) or down (0). The counter wraps modulo 2^54, and holds its value while bit 0 is 0.
- R5: Alarm (0x08 low, 0x0C high) and preset (0x10 low, 0x14 high) values are 54 bits wide. A write to the low word is only staged. The full value, including that staged low word, is committed by the write to the high word.
- R6: Writing 1 to bit 0 of the load register (0x18) copies the committed preset value into the counter on that clock edge. This takes priority over counting.
- R7: When control bit 3 (alarm armed) is 1 and the count is at or past the alarm value, an alarm event occurs. "At or past" means count >= alarm when counting up, and count <= alarm when counting down. On the event, bit 3 clears by itself, so each arming yields exactly one event.
- R8: With control bit 2 (auto-reload) set, an alarm event loads the preset value into the counter instead of stepping it.
- R9: Writing 1 to bit 0 of the snapshot register (0x1C) sets that bit. The bit reads 0 again 2*SYNC_STAGES+2 clocks after the write. From then on, 0x20 holds count bits 31:0 and 0x24 holds bits 53:32, as captured SYNC_STAGES+1 clocks after the write. A snapshot write made while the bit is 1 is ignored.
- R10: The alarm event sets raw status bit 0 (0x2C). Status (0x30) reads raw AND mask bit 0 (0x28), and `irq` equals that status. Writing 1 to bit 0 of 0x34 clears raw status. An alarm event in the same cycle as a clear wins.
- R11: The clock-select register (0x38, bits 1:0) drives `clk_sel`:
  - 0 selects the crystal.
  - 1 selects the fast internal RC.
  - 2 selects the 80 MHz PLL clock.
  - A write of code 3 leaves the selection unchanged.
- R12: High words (0x0C, 0x14, 0x24) return the upper 22 value bits in bits 21:0, with bits 31:22 reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for registers and counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, raw alarm status AND mask |
| clk_sel | output | 2 | Source-clock select code |

## Verification
A wrong prescaler phase or step direction does not appear at `irq` until the next alarm. It appears at the count words only after a snapshot round trip, so a phase error shows up one ratio period plus the handshake latency later. A stuck snapshot handshake shows within 2*SYNC_STAGES+2 clocks, because the snapshot bit fails to drop. A missed alarm self-clear appears as a second `irq` rise right after a clear, while the counter is still past the threshold. The reference model tracks every register and the counter on each clock and compares `irq`, `clk_sel` and the read word on every cycle, so most divergences surface within one clock of being readable.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_CTRL   = 6'h00;
  localparam logic [ADDR_W-1:0] A_DIV    = 6'h04;
  localparam logic [ADDR_W-1:0] A_ALM_LO = 6'h08;
  localparam logic [ADDR_W-1:0] A_ALM_HI = 6'h0C;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 6'h10;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 6'h14;
  localparam logic [ADDR_W-1:0] A_LOAD   = 6'h18;
  localparam logic [ADDR_W-1:0] A_SNAP   = 6'h1C;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 6'h20;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 6'h24;
  localparam logic [ADDR_W-1:0] A_IEN    = 6'h28;
  localparam logic [ADDR_W-1:0] A_IRAW   = 6'h2C;
  localparam logic [ADDR_W-1:0] A_IST    = 6'h30;
  localparam logic [ADDR_W-1:0] A_ICLR   = 6'h34;
  localparam logic [ADDR_W-1:0] A_CSEL   = 6'h38;

  localparam int B_RUN  = 0;
  localparam int B_UP   = 1;
  localparam int B_ARLD = 2;
  localparam int B_ARM  = 3;

  typedef enum logic [1:0] {
    SRC_CRYSTAL = 2'd0,
    SRC_FAST_RC = 2'd1,
    SRC_PLL80   = 2'd2,
    SRC_RSVD    = 2'd3
  } clk_src_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_field,
  output logic             tick
);
  logic [DIV_W-1:0] limit;
  logic [DIV_W-1:0] phase;

  // field 0 -> full 2^DIV_W ratio, field 1 -> treated as 2
  always_comb begin
    if (div_field == '0)                    limit = '1;
    else if (div_field == DIV_W'(1))        limit = DIV_W'(1);
    else                                    limit = div_field - DIV_W'(1);
  end

  assign tick = run && (phase == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (run)     phase <= (phase == limit) ? '0 : phase + DIV_W'(1);
  end

  p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= limit);
  p_restart_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase == '0));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 54
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             count_up,
  input  logic             soft_load,
  input  logic             armed,
  input  logic             auto_reload,
  input  logic [CNT_W-1:0] alarm_val,
  input  logic [CNT_W-1:0] preset_val,
  output logic [CNT_W-1:0] count,
  output logic             fire
);
  logic reach;
  logic take_preset;

  assign reach       = count_up ? (count >= alarm_val) : (count <= alarm_val);
  assign fire        = armed && reach;
  assign take_preset = soft_load || (fire && auto_reload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           count <= '0;
    else if (take_preset) count <= preset_val;
    else if (tick)        count <= count_up ? count + CNT_W'(1) : count - CNT_W'(1);
  end

  p_soft_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_load |=> (count == $past(preset_val)));
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !soft_load && !(fire && auto_reload)) |=> $stable(count));
  p_reload_on_alarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && auto_reload) |=> (count == $past(preset_val)));
endmodule

// File: rtl/tmr_snap_xfer.sv
module tmr_snap_xfer #(
  parameter int CNT_W       = 54,
  parameter int SYNC_STAGES = 2
) (
  input  logic             tclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] live_count,
  input  logic             req,
  output logic             busy,
  output logic [CNT_W-1:0] snap
);
  logic                   req_tgl;
  logic [SYNC_STAGES-1:0] req_sync;
  logic                   req_last;
  logic                   ack_tgl;
  logic [SYNC_STAGES-1:0] ack_sync;
  logic                   ack_last;
  logic [CNT_W-1:0]       hold;
  logic                   req_edge;
  logic                   ack_edge;

  assign req_edge = req_sync[SYNC_STAGES-1] ^ req_last;
  assign ack_edge = ack_sync[SYNC_STAGES-1] ^ ack_last;

  // register side: issue request, wait for the acknowledge
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl  <= 1'b0;
      ack_sync <= '0;
      ack_last <= 1'b0;
      busy     <= 1'b0;
      snap     <= '0;
    end else begin
      ack_sync <= {ack_sync[SYNC_STAGES-2:0], ack_tgl};
      if (ack_edge) begin
        ack_last <= ack_sync[SYNC_STAGES-1];
        busy     <= 1'b0;
        snap     <= hold;
      end
      if (req && !busy) begin
        req_tgl <= ~req_tgl;
        busy    <= 1'b1;
      end
    end
  end

  // timer side: capture the live count once per request
  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      req_sync <= '0;
      req_last <= 1'b0;
      ack_tgl  <= 1'b0;
      hold     <= '0;
    end else begin
      req_sync <= {req_sync[SYNC_STAGES-2:0], req_tgl};
      if (req_edge) begin
        req_last <= req_sync[SYNC_STAGES-1];
        hold     <= live_count;
        ack_tgl  <= ~ack_tgl;
      end
    end
  end

  p_snap_only_on_done_r9: assert property (@(posedge rclk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(snap));
  p_hold_quiet_r9: assert property (@(posedge tclk) disable iff (!rst_n)
    !req_edge |=> $stable(hold));
  p_busy_sticky_r9: assert property (@(posedge rclk) disable iff (!rst_n)
    (busy && !ack_edge) |=> busy);
endmodule

// File: rtl/tmr_alarm_timer.sv
module tmr_alarm_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 54,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq,
  output logic [1:0]        clk_sel
);
  localparam int HI_W  = CNT_W - WORD_W;
  localparam int PAD_H = WORD_W - HI_W;
  localparam int PAD_D = WORD_W - DIV_W;

  logic r_run, r_up, r_arld, r_arm;
  logic [DIV_W-1:0]  r_div;
  logic [WORD_W-1:0] alm_stage, rld_stage;
  logic [CNT_W-1:0]  alm_val, rld_val;
  logic r_ien, r_iraw;
  clk_src_e r_csel;

  logic wr_ctrl, wr_div, wr_alm_lo, wr_alm_hi, wr_rld_lo, wr_rld_hi;
  logic wr_iclr, wr_ien, wr_csel;
  logic soft_load, snap_req;
  logic tick, fire, snap_busy;
  logic [CNT_W-1:0] live_count, snap_val;

  assign wr_ctrl   = bus_we && (bus_addr == A_CTRL);
  assign wr_div    = bus_we && (bus_addr == A_DIV);
  assign wr_alm_lo = bus_we && (bus_addr == A_ALM_LO);
  assign wr_alm_hi = bus_we && (bus_addr == A_ALM_HI);
  assign wr_rld_lo = bus_we && (bus_addr == A_RLD_LO);
  assign wr_rld_hi = bus_we && (bus_addr == A_RLD_HI);
  assign wr_iclr   = bus_we && (bus_addr == A_ICLR) && bus_wdata[0];
  assign wr_ien    = bus_we && (bus_addr == A_IEN);
  assign wr_csel   = bus_we && (bus_addr == A_CSEL);
  assign soft_load = bus_we && (bus_addr == A_LOAD) && bus_wdata[0];
  assign snap_req  = bus_we && (bus_addr == A_SNAP) && bus_wdata[0];

  // control and configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_run     <= 1'b0;
      r_up      <= 1'b1;
      r_arld    <= 1'b0;
      r_arm     <= 1'b0;
      r_div     <= DIV_W'(2);
      alm_stage <= '0;
      rld_stage <= '0;
      alm_val   <= '0;
      rld_val   <= '0;
      r_ien     <= 1'b0;
      r_iraw    <= 1'b0;
      r_csel    <= SRC_CRYSTAL;
    end else begin
      if (wr_ctrl) begin
        r_run  <= bus_wdata[B_RUN];
        r_up   <= bus_wdata[B_UP];
        r_arld <= bus_wdata[B_ARLD];
        r_arm  <= bus_wdata[B_ARM];
      end else if (fire) begin
        r_arm  <= 1'b0;
      end
      if (wr_div)    r_div     <= bus_wdata[DIV_W-1:0];
      if (wr_alm_lo) alm_stage <= bus_wdata;
      if (wr_rld_lo) rld_stage <= bus_wdata;
      if (wr_alm_hi) alm_val   <= {bus_wdata[HI_W-1:0], alm_stage};
      if (wr_rld_hi) rld_val   <= {bus_wdata[HI_W-1:0], rld_stage};
      if (wr_ien)    r_ien     <= bus_wdata[0];
      if (fire)         r_iraw <= 1'b1;
      else if (wr_iclr) r_iraw <= 1'b0;
      if (wr_csel && (clk_src_e'(bus_wdata[1:0]) != SRC_RSVD))
        r_csel <= clk_src_e'(bus_wdata[1:0]);
    end
  end

  tmr_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (r_run),
    .restart   (wr_div),
    .div_field (r_div),
    .tick      (tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .count_up    (r_up),
    .soft_load   (soft_load),
    .armed       (r_arm),
    .auto_reload (r_arld),
    .alarm_val   (alm_val),
    .preset_val  (rld_val),
    .count       (live_count),
    .fire        (fire)
  );

  tmr_snap_xfer #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_snap (
    .tclk       (clk),
    .rclk       (clk),
    .rst_n      (rst_n),
    .live_count (live_count),
    .req        (snap_req),
    .busy       (snap_busy),
    .snap       (snap_val)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:   bus_rdata = {{(WORD_W-4){1'b0}}, r_arm, r_arld, r_up, r_run};
      A_DIV:    bus_rdata = {{PAD_D{1'b0}}, r_div};
      A_ALM_LO: bus_rdata = alm_val[WORD_W-1:0];
      A_ALM_HI: bus_rdata = {{PAD_H{1'b0}}, alm_val[CNT_W-1:WORD_W]};
      A_RLD_LO: bus_rdata = rld_val[WORD_W-1:0];
      A_RLD_HI: bus_rdata = {{PAD_H{1'b0}}, rld_val[CNT_W-1:WORD_W]};
      A_SNAP:   bus_rdata = {{(WORD_W-1){1'b0}}, snap_busy};
      A_CNT_LO: bus_rdata = snap_val[WORD_W-1:0];
      A_CNT_HI: bus_rdata = {{PAD_H{1'b0}}, snap_val[CNT_W-1:WORD_W]};
      A_IEN:    bus_rdata = {{(WORD_W-1){1'b0}}, r_ien};
      A_IRAW:   bus_rdata = {{(WORD_W-1){1'b0}}, r_iraw};
      A_IST:    bus_rdata = {{(WORD_W-1){1'b0}}, r_iraw & r_ien};
      A_CSEL:   bus_rdata = {{(WORD_W-2){1'b0}}, r_csel};
      default:  bus_rdata = '0;
    endcase
  end

  assign irq     = r_iraw & r_ien;
  assign clk_sel = r_csel;

  p_one_shot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr_ctrl) |=> !r_arm);
  p_raw_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (r_iraw && !wr_iclr) |=> r_iraw);
  p_event_sets_raw_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> r_iraw);
  p_csel_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    r_csel != SRC_RSVD);
  p_alarm_staged_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_alm_hi |=> $stable(alm_val));
endmodule

// File: tb/tmr_alarm_timer_tb_top.sv
`timescale 1ns/1ps
module tmr_alarm_timer_tb_top;
  import tmr_pkg::*;
  localparam int CW = 54;
  localparam int S  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         irq;
  wire  [1:0]  csel;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  tmr_alarm_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .clk_sel(csel)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model state
  logic m_run, m_up, m_arld, m_arm, m_ien, m_iraw, m_busy;
  logic [15:0] m_div;
  logic [31:0] m_alo, m_rlo;
  logic [CW-1:0] m_alm, m_rld, m_cnt, m_hold, m_snap;
  logic [1:0] m_csel;
  int m_phase, m_cap, m_pub;

  always @(posedge clk or negedge rst_n) begin : model
    int r;
    logic t, f, b0;
    if (!rst_n) begin
      m_run = 0; m_up = 1; m_arld = 0; m_arm = 0; m_ien = 0; m_iraw = 0;
      m_busy = 0; m_div = 2; m_alo = 0; m_rlo = 0; m_alm = 0; m_rld = 0;
      m_cnt = 0; m_hold = 0; m_snap = 0; m_csel = 0; m_phase = 0;
      m_cap = 0; m_pub = 0;
    end else begin
      r  = (m_div == 0) ? 65536 : (m_div == 1) ? 2 : int'(m_div);
      t  = m_run && (m_phase == r - 1);
      f  = m_arm && (m_up ? (m_cnt >= m_alm) : (m_cnt <= m_alm));
      b0 = m_busy;
      if (m_cap > 0) begin m_cap--; if (m_cap == 0) m_hold = m_cnt; end
      if (m_pub > 0) begin m_pub--; if (m_pub == 0) begin m_busy = 0; m_snap = m_hold; end end
      if (we && addr == A_LOAD && wdata[0]) m_cnt = m_rld;
      else if (f && m_arld)                 m_cnt = m_rld;
      else if (t)                           m_cnt = m_up ? m_cnt + 1 : m_cnt - 1;
      if (we && addr == A_DIV) m_phase = 0;
      else if (m_run)          m_phase = (m_phase == r - 1) ? 0 : m_phase + 1;
      if (f) m_arm = 0;
      if (f) m_iraw = 1;
      else if (we && addr == A_ICLR && wdata[0]) m_iraw = 0;
      if (we) begin
        case (addr)
          A_CTRL:   begin m_run = wdata[0]; m_up = wdata[1]; m_arld = wdata[2]; m_arm = wdata[3]; end
          A_DIV:    m_div = wdata[15:0];
          A_ALM_LO: m_alo = wdata;
          A_ALM_HI: m_alm = {wdata[21:0], m_alo};
          A_RLD_LO: m_rlo = wdata;
          A_RLD_HI: m_rld = {wdata[21:0], m_rlo};
          A_SNAP:   if (wdata[0] && !b0) begin m_busy = 1; m_cap = S + 1; m_pub = 2 * S + 2; end
          A_IEN:    m_ien = wdata[0];
          A_CSEL:   if (wdata[1:0] != 2'd3) m_csel = wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] mrd(logic [5:0] a);
    case (a)
      A_CTRL:   return {28'd0, m_arm, m_arld, m_up, m_run};
      A_DIV:    return {16'd0, m_div};
      A_ALM_LO: return m_alm[31:0];
      A_ALM_HI: return {10'd0, m_alm[53:32]};
      A_RLD_LO: return m_rld[31:0];
      A_RLD_HI: return {10'd0, m_rld[53:32]};
      A_SNAP:   return {31'd0, m_busy};
      A_CNT_LO: return m_snap[31:0];
      A_CNT_HI: return {10'd0, m_snap[53:32]};
      A_IEN:    return {31'd0, m_ien};
      A_IRAW:   return {31'd0, m_iraw};
      A_IST:    return {31'd0, m_iraw & m_ien};
      A_CSEL:   return {30'd0, m_csel};
      default:  return 32'd0;
    endcase
  endfunction

  function automatic string tagof(logic [5:0] a);
    case (a)
      A_CTRL:                       return "R7 ctrl readback";
      A_DIV:                        return "R2 divider readback";
      A_ALM_LO, A_ALM_HI,
      A_RLD_LO, A_RLD_HI:           return "R5 value readback";
      A_SNAP, A_CNT_LO, A_CNT_HI:   return "R9 snapshot readback";
      A_IEN, A_IRAW, A_IST:         return "R10 interrupt readback";
      A_CSEL:                       return "R11 select readback";
      default:                      return "R12 unmapped readback";
    endcase
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      #1;
      chk(tagof(addr), {32'd0, rdata}, {32'd0, mrd(addr)});
      chk("R10 irq pin", {63'd0, irq}, {63'd0, m_iraw & m_ien});
      chk("R11 clk_sel pin", {62'd0, csel}, {62'd0, m_csel});
    end
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rdx(string tag, logic [5:0] a, logic [31:0] e);
    @(negedge clk); we = 1'b0; addr = a;
    #2; chk(tag, {32'd0, rdata}, {32'd0, e});
  endtask

  task automatic take_snap();
    wr(A_SNAP, 32'd1);
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (irq !== 1'b1) begin @(negedge clk); n++; end
  endtask

  task automatic ratio_run(logic [15:0] d, int exp_n, string tag);
    int n;
    wr(A_CTRL, 32'h2);
    wr(A_ICLR, 32'h1);
    wr(A_DIV, {16'd0, d});
    wr(A_LOAD, 32'h1);
    wr(A_CTRL, 32'hB);
    wait_irq(n);
    chk(tag, 64'(n), 64'(exp_n));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rdx("R1 ctrl reset", A_CTRL, 32'h2);
    rdx("R1 divider reset", A_DIV, 32'h2);
    rdx("R1 count reset", A_CNT_LO, 32'h0);
    rdx("R1 select reset", A_CSEL, 32'h0);
    chk("R1 irq reset", {63'd0, irq}, 64'd0);
    // R5 staging
    wr(A_RLD_LO, 32'h1234_5678);
    rdx("R5 low staged only", A_RLD_LO, 32'h0);
    wr(A_RLD_HI, 32'h2A);
    rdx("R5 commit low", A_RLD_LO, 32'h1234_5678);
    rdx("R5 commit high", A_RLD_HI, 32'h2A);
    // R6 soft load, R9 snapshot
    wr(A_LOAD, 32'h1);
    wr(A_SNAP, 32'h1);
    chk("R9 busy after request", {32'd0, rdata}, 64'd1);
    repeat (8) @(negedge clk);
    rdx("R6 loaded low", A_CNT_LO, 32'h1234_5678);
    rdx("R6 loaded high", A_CNT_HI, 32'h2A);
    // R9 busy latency and ignored re-request
    wr(A_SNAP, 32'h1);
    n = 0; while (rdata[0]) begin @(negedge clk); n++; end
    chk("R9 busy length", 64'(n), 64'(2 * S + 2));
    wr(A_SNAP, 32'h1);
    wr(A_SNAP, 32'h1);
    n = 0; while (rdata[0]) begin @(negedge clk); n++; end
    chk("R9 request while busy ignored", 64'(n), 64'(2 * S));
    // R4 wrap both directions
    wr(A_DIV, 32'd2);
    wr(A_RLD_LO, 32'h0);
    wr(A_RLD_HI, 32'h0);
    wr(A_LOAD, 32'h1);
    wr(A_CTRL, 32'h1);
    wr(A_CTRL, 32'h0);
    take_snap();
    rdx("R4 down wrap low", A_CNT_LO, 32'hFFFF_FFFF);
    rdx("R12 down wrap high", A_CNT_HI, 32'h003F_FFFF);
    wr(A_CTRL, 32'h3);
    wr(A_CTRL, 32'h2);
    take_snap();
    rdx("R4 up wrap low", A_CNT_LO, 32'h0);
    rdx("R4 up wrap high", A_CNT_HI, 32'h0);
    // R2 ratios via alarm at 1
    wr(A_ALM_LO, 32'h1);
    wr(A_ALM_HI, 32'h0);
    wr(A_IEN, 32'h1);
    ratio_run(16'd3, 4, "R2 ratio 3");
    // R7 one-shot
    rdx("R7 arm self-cleared", A_CTRL, 32'h3);
    wr(A_ICLR, 32'h1);
    repeat (20) @(negedge clk);
    chk("R7 no second event", {63'd0, irq}, 64'd0);
    ratio_run(16'd1, 3, "R2 field 1 as ratio 2");
    ratio_run(16'd0, 65537, "R2 field 0 as 65536");
    // R3 divider restart
    wr(A_CTRL, 32'h2);
    wr(A_ICLR, 32'h1);
    wr(A_DIV, 32'd4);
    wr(A_LOAD, 32'h1);
    wr(A_CTRL, 32'hB);
    wr(A_DIV, 32'd4);
    wait_irq(n);
    chk("R3 phase restart", 64'(n), 64'd5);
    // R8 auto-reload
    wr(A_CTRL, 32'h2);
    wr(A_ICLR, 32'h1);
    wr(A_DIV, 32'd2);
    wr(A_RLD_LO, 32'd100);
    wr(A_RLD_HI, 32'h0);
    wr(A_ALM_LO, 32'd103);
    wr(A_ALM_HI, 32'h0);
    wr(A_LOAD, 32'h1);
    wr(A_CTRL, 32'hF);
    wait_irq(n);
    wr(A_CTRL, 32'h6);
    take_snap();
    rdx("R8 reloaded then stepped", A_CNT_LO, 32'd101);
    rdx("R8 high word", A_CNT_HI, 32'd0);
    // R10 mask and clear
    wr(A_IEN, 32'h0);
    rdx("R10 masked status", A_IST, 32'h0);
    chk("R10 masked irq", {63'd0, irq}, 64'd0);
    rdx("R10 raw kept", A_IRAW, 32'h1);
    wr(A_IEN, 32'h1);
    chk("R10 unmasked irq", {63'd0, irq}, 64'd1);
    wr(A_ICLR, 32'h1);
    rdx("R10 cleared raw", A_IRAW, 32'h0);
    // R11 clock select
    wr(A_CSEL, 32'h2);
    chk("R11 pll code", {62'd0, csel}, 64'd2);
    wr(A_CSEL, 32'h3);
    chk("R11 code 3 ignored", {62'd0, csel}, 64'd2);
    wr(A_CSEL, 32'h1);
    chk("R11 rc code", {62'd0, csel}, 64'd1);
    // R12 high word masking
    wr(A_ALM_HI, 32'hFFFF_FFFF);
    rdx("R12 alarm high width", A_ALM_HI, 32'h003F_FFFF);
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule